// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the pins of one GPIO bank, organised as several ports of eight pins, and raises one interrupt line for the whole bank. Each pin has its own trigger setting, an enable bit and a status bit. The trigger can be a rising edge, a falling edge, either edge, a high level or a low level. Software programs the block through a simple register bus. It reads which pins are pending and clears them by writing ones to a clear register.

The pin inputs must already be synchronised to `clk`. Edges are found by comparing each pin with its own sample from the previous clock. The trigger setting of a port is held as three bit planes in one word: a polarity plane, an edge-select plane and a dual-edge plane. A masked-write alias region lets software change single enable bits or single polarity bits without a read-modify-write.

Top module: `gpirq_bank`

## Requirements
- R1: Synchronous active-high reset clears every enable bit, every status bit and every trigger word, and drives `irq_o` and `bus_rdata` to 0.
- R2: Register map for port p, at byte offsets: status at 0x40+4p (read-only, writes ignored), enable at 0x50+4p (bits 7:0), trigger at 0x60+4p (bits 23:0), clear at 0x70+4p (write-only, reads 0). Any other address reads 0. `bus_rdata` is registered and shows the register addressed in the previous cycle, with the value that register held before that clock edge.
- R3: For pin n, trigger bit n is polarity (1 = high/rising), bit 8+n selects edge mode and bit 16+n selects both edges. The encodings are: rising = bits 8+n and n; falling = bit 8+n only; both = bits 16+n and 8+n; high level = bit n only; low level = none of the three.
- R4: In rising or falling mode, a matching transition sets the status bit at the clock edge that first samples the new pin level. A transition counts when the pin differs from its sample one clock earlier. The bit then stays set until it is cleared; a transition in the other direction does not set it.
- R5: In both-edges mode, either transition sets the status bit.
- R6: In level mode, the status bit is set on every clock in which the pin is at its active level. A clear written while that level persists has no effect. Once the level is gone, the bit stays set until it is cleared.
- R7: Writing 1 to bit n of a clear register clears status bit n of that port. Bits written as 0 leave their status bit unchanged. A status bit never falls without such a clear.
- R8: If a matching edge and a clear of the same pin happen in the same cycle, the status bit stays set.
- R9: `irq_o` is high exactly one clock after any port has a pin whose status bit and enable bit are both 1.
- R10: A write to the masked enable alias at UPPER_OFS+0x50+4p (0xD0+4p by default) updates only the enable bits selected by mask bits 15:8, giving them value bits 7:0. A mask of 0 changes nothing.
- R11: A write to the masked trigger alias at UPPER_OFS+0x60+4p (0xE0+4p by default) updates only the polarity-plane bits selected by mask bits 15:8, giving them value bits 7:0. The edge and dual planes are left as they are.
- R12: A status bit records its trigger condition whether or not the pin is enabled. A disabled pin never drives `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPORT*PINS | Synchronised pin levels; bit p*PINS+n is pin n of port p |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered bank interrupt |

## Verification
A status bit changes at the same clock edge that first samples a new pin level or a clear write. `irq_o` follows one edge after the status and enable bits that drive it. Read data is due one edge after its address is presented and shows the state from before that edge. The bench keeps a model of the registers. Before each edge it forms the expected `irq_o` and read data from the model state as it stands before the edge, and only then advances the model. It drives inputs on the falling edge and compares outputs on the next falling edge, so every comparison lands exactly in the cycle where the result is due.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

  localparam int OFS_STS = 'h40;
  localparam int OFS_EN  = 'h50;
  localparam int OFS_TRG = 'h60;
  localparam int OFS_CLR = 'h70;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STS,
    RD_EN,
    RD_TRG
  } rd_sel_e;

  // Trigger decision for one pin from its three plane bits.
  function automatic logic trig_hit(input logic pol, input logic edg,
                                    input logic dual, input logic cur,
                                    input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (edg) begin
      if (dual) trig_hit = rise | fall;
      else      trig_hit = pol ? rise : fall;
    end else begin
      trig_hit = (cur == pol);
    end
  endfunction

endpackage

// File: rtl/gpirq_regdec.sv
module gpirq_regdec
  import gpirq_pkg::*;
#(
  parameter int NPORT     = 4,
  parameter int ADDR_W    = 12,
  parameter int UPPER_OFS = 'h80,
  localparam int PORT_W   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NPORT-1:0]  we_en,
  output logic [NPORT-1:0]  we_en_msk,
  output logic [NPORT-1:0]  we_trg,
  output logic [NPORT-1:0]  we_trg_msk,
  output logic [NPORT-1:0]  we_clr,
  output rd_sel_e           rd_sel,
  output logic [PORT_W-1:0] rd_port
);

  always_comb begin
    we_en      = '0;
    we_en_msk  = '0;
    we_trg     = '0;
    we_trg_msk = '0;
    we_clr     = '0;
    rd_sel     = RD_NONE;
    rd_port    = '0;
    for (int p = 0; p < NPORT; p++) begin
      we_en[p]      = bus_we && (bus_addr == ADDR_W'(OFS_EN + 4*p));
      we_en_msk[p]  = bus_we && (bus_addr == ADDR_W'(UPPER_OFS + OFS_EN + 4*p));
      we_trg[p]     = bus_we && (bus_addr == ADDR_W'(OFS_TRG + 4*p));
      we_trg_msk[p] = bus_we && (bus_addr == ADDR_W'(UPPER_OFS + OFS_TRG + 4*p));
      we_clr[p]     = bus_we && (bus_addr == ADDR_W'(OFS_CLR + 4*p));
      if (bus_addr == ADDR_W'(OFS_STS + 4*p)) begin
        rd_sel  = RD_STS;
        rd_port = PORT_W'(p);
      end
      if (bus_addr == ADDR_W'(OFS_EN + 4*p)) begin
        rd_sel  = RD_EN;
        rd_port = PORT_W'(p);
      end
      if (bus_addr == ADDR_W'(OFS_TRG + 4*p)) begin
        rd_sel  = RD_TRG;
        rd_port = PORT_W'(p);
      end
    end
  end

endmodule

// File: rtl/gpirq_port.sv
module gpirq_port
  import gpirq_pkg::*;
#(
  parameter int PINS    = 8,
  localparam int TRIG_W = 3 * PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   pin_i,
  input  logic [TRIG_W-1:0] wdata,
  input  logic              we_en,
  input  logic              we_en_msk,
  input  logic              we_trg,
  input  logic              we_trg_msk,
  input  logic              we_clr,
  output logic [PINS-1:0]   sts_o,
  output logic [PINS-1:0]   en_o,
  output logic [TRIG_W-1:0] trig_o
);

  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] hit;
  logic [PINS-1:0] clr;
  logic [PINS-1:0] msk;
  logic [PINS-1:0] val;
  logic            unused_top;

  assign val        = wdata[PINS-1:0];
  assign msk        = wdata[2*PINS-1:PINS];
  assign clr        = we_clr ? val : '0;
  assign unused_top = ^wdata[TRIG_W-1:2*PINS];

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    assign hit[n] = trig_hit(trig_o[n], trig_o[PINS+n], trig_o[2*PINS+n],
                             pin_i[n], prev_q[n]);
  end

  always_ff @(posedge clk) begin
    prev_q <= pin_i;
    if (rst) begin
      sts_o  <= '0;
      en_o   <= '0;
      trig_o <= '0;
    end else begin
      // a new hit outranks a clear of the same bit
      sts_o <= (sts_o & ~clr) | hit;
      if (we_en)
        en_o <= val;
      else if (we_en_msk)
        en_o <= (en_o & ~msk) | (val & msk);
      if (we_trg)
        trig_o <= wdata;
      else if (we_trg_msk)
        trig_o[PINS-1:0] <= (trig_o[PINS-1:0] & ~msk) | (val & msk);
    end
  end

endmodule

// File: rtl/gpirq_bank.sv
module gpirq_bank
  import gpirq_pkg::*;
#(
  parameter int NPORT     = 4,
  parameter int PINS      = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int UPPER_OFS = 'h80,
  localparam int NPIN     = NPORT * PINS,
  localparam int TRIG_W   = 3 * PINS,
  localparam int PORT_W   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  logic [NPORT-1:0][PINS-1:0]   sts_all;
  logic [NPORT-1:0][PINS-1:0]   en_all;
  logic [NPORT-1:0][TRIG_W-1:0] trig_all;
  logic [NPORT-1:0] we_en, we_en_msk, we_trg, we_trg_msk, we_clr;
  rd_sel_e            rd_sel;
  logic [PORT_W-1:0]  rd_port;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wd;

  assign unused_wd = ^bus_wdata[DATA_W-1:TRIG_W];

  gpirq_regdec #(
    .NPORT(NPORT), .ADDR_W(ADDR_W), .UPPER_OFS(UPPER_OFS)
  ) u_dec (
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .we_en      (we_en),
    .we_en_msk  (we_en_msk),
    .we_trg     (we_trg),
    .we_trg_msk (we_trg_msk),
    .we_clr     (we_clr),
    .rd_sel     (rd_sel),
    .rd_port    (rd_port)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gpirq_port #(.PINS(PINS)) u_port (
      .clk        (clk),
      .rst        (rst),
      .pin_i      (pin_i[p*PINS +: PINS]),
      .wdata      (bus_wdata[TRIG_W-1:0]),
      .we_en      (we_en[p]),
      .we_en_msk  (we_en_msk[p]),
      .we_trg     (we_trg[p]),
      .we_trg_msk (we_trg_msk[p]),
      .we_clr     (we_clr[p]),
      .sts_o      (sts_all[p]),
      .en_o       (en_all[p]),
      .trig_o     (trig_all[p])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (rd_sel)
      RD_STS:  rd_mux = DATA_W'(sts_all[rd_port]);
      RD_EN:   rd_mux = DATA_W'(en_all[rd_port]);
      RD_TRG:  rd_mux = DATA_W'(trig_all[rd_port]);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq_o     <= |(sts_all & en_all);
    end
  end

endmodule

// File: rtl/gpirq_chk.sv
module gpirq_chk
  import gpirq_pkg::*;
#(
  parameter int NPORT     = 4,
  parameter int PINS      = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int UPPER_OFS = 'h80,
  localparam int NPIN     = NPORT * PINS,
  localparam int TRIG_W   = 3 * PINS
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NPIN-1:0]              pin_i,
  input logic                         bus_we,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [DATA_W-1:0]            bus_wdata,
  input logic [NPORT-1:0][PINS-1:0]   sts_all,
  input logic [NPORT-1:0][PINS-1:0]   en_all,
  input logic [NPORT-1:0][TRIG_W-1:0] trig_all,
  input logic                         irq_o
);

  logic [NPORT-1:0][PINS-1:0] clr_v;
  logic [NPORT-1:0][PINS-1:0] lvl_act;
  logic                       msk_en_hit;
  logic                       unused_c;

  assign unused_c = ^trig_all ^ ^bus_wdata;

  always_comb begin
    msk_en_hit = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (bus_we && bus_addr == ADDR_W'(UPPER_OFS + OFS_EN + 4*p))
        msk_en_hit = 1'b1;
      for (int n = 0; n < PINS; n++) begin
        clr_v[p][n]   = bus_we && (bus_addr == ADDR_W'(OFS_CLR + 4*p)) && bus_wdata[n];
        lvl_act[p][n] = !trig_all[p][PINS+n] && (trig_all[p][n] == pin_i[p*PINS+n]);
      end
    end
  end

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (en_all == '0 && sts_all == '0 && !irq_o)); // R1

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_o == |($past(sts_all) & $past(en_all)))); // R9

  AST_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((($past(sts_all) & ~sts_all) & ~$past(clr_v)) == '0)); // R7

  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (($past(lvl_act) & ~sts_all) == '0)); // R6

  AST_MSK_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (msk_en_hit && bus_wdata[2*PINS-1:PINS] == '0) |=> $stable(en_all)); // R10

endmodule

bind gpirq_bank gpirq_chk #(
  .NPORT(NPORT), .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UPPER_OFS(UPPER_OFS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pin_i     (pin_i),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .sts_all   (sts_all),
  .en_all    (en_all),
  .trig_all  (trig_all),
  .irq_o     (irq_o)
);

// File: tb/sim_gpirq_bank.sv
module sim_gpirq_bank;
  localparam int NP = 4;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int UP = 'h80;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   pins = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  wire  [DW-1:0] rdata;
  wire           irq;

  always #4 clk = ~clk;

  gpirq_bank #(.NPORT(NP), .PINS(8), .ADDR_W(AW), .DATA_W(DW), .UPPER_OFS(UP)) u0 (
    .clk(clk), .rst(rst), .pin_i(pins), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] last_rd;
  logic [7:0]  m_sts [NP];
  logic [7:0]  m_en  [NP];
  logic [23:0] m_trg [NP];
  logic [31:0] m_prev;

  function automatic logic [31:0] mread(logic [AW-1:0] a);
    mread = '0;
    for (int p = 0; p < NP; p++) begin
      if (a == AW'('h40 + 4*p)) mread = {24'b0, m_sts[p]};
      if (a == AW'('h50 + 4*p)) mread = {24'b0, m_en[p]};
      if (a == AW'('h60 + 4*p)) mread = {8'b0, m_trg[p]};
    end
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      for (int p = 0; p < NP; p++) begin
        m_sts[p] = '0; m_en[p] = '0; m_trg[p] = '0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        logic [7:0] ns;
        for (int n = 0; n < 8; n++) begin
          logic pol, ed, du, cur, pv, hit, clr;
          pol = m_trg[p][n]; ed = m_trg[p][8+n]; du = m_trg[p][16+n];
          cur = pins[p*8+n]; pv = m_prev[p*8+n];
          if (ed) hit = du ? (cur ^ pv) : (pol ? (cur & ~pv) : (~cur & pv));
          else    hit = (cur == pol);
          clr = we && addr == AW'('h70 + 4*p) && wdata[n];
          ns[n] = (m_sts[p][n] & ~clr) | hit;
        end
        m_sts[p] = ns;
        if (we && addr == AW'('h50 + 4*p)) m_en[p] = wdata[7:0];
        if (we && addr == AW'(UP + 'h50 + 4*p))
          m_en[p] = (m_en[p] & ~wdata[15:8]) | (wdata[7:0] & wdata[15:8]);
        if (we && addr == AW'('h60 + 4*p)) m_trg[p] = wdata[23:0];
        if (we && addr == AW'(UP + 'h60 + 4*p))
          m_trg[p][7:0] = (m_trg[p][7:0] & ~wdata[15:8]) | (wdata[7:0] & wdata[15:8]);
      end
    end
    m_prev = pins;
  endtask

  // one clock: expectations from pre-edge model state, then compare
  task automatic tick(string tag);
    logic        e_irq;
    logic [31:0] e_rd;
    e_irq = 1'b0;
    for (int p = 0; p < NP; p++) e_irq |= |(m_sts[p] & m_en[p]);
    e_rd = mread(addr);
    if (rst) begin e_irq = 1'b0; e_rd = '0; end
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, e_irq});
    chk({tag, " rdata"}, rdata, e_rd);
    last_rd = rdata;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, string tag);
    we = 1'b1; addr = a; wdata = d;
    tick(tag);
    we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    addr = a;
    tick(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) tick("R1 reset");
    rst = 1'b0;
    rd('h50, "R1"); chk("R1 enable after reset", last_rd, 32'h0);
    rd('h6C, "R1"); chk("R1 trigger after reset", last_rd, 32'h0);
    // default trigger is low level, pins low, nothing enabled
    rd('h40, "R12"); chk("R12 status records while disabled", last_rd, 32'hFF);
    chk("R12 no irq while disabled", {31'b0, irq}, 32'h0);
    wr('h40, 32'h0, "R2"); rd('h40, "R2");
    chk("R2 status write ignored", last_rd, 32'hFF);
    rd('h70, "R2"); chk("R2 clear reads zero", last_rd, 32'h0);

    // port0 pin2 rising, others level high
    wr('h60, 32'h0000_04FF, "R3"); wr('h70, 32'hFF, "R7"); wr('h50, 32'h04, "R9");
    tick("R9"); chk("R9 irq idle", {31'b0, irq}, 32'h0);
    pins[2] = 1'b1; tick("R4"); tick("R9");
    chk("R9 irq after rising edge", {31'b0, irq}, 32'h1);
    rd('h40, "R4"); chk("R4 rising sets status", last_rd, 32'h04);
    pins[2] = 1'b0; tick("R4"); tick("R4");
    rd('h40, "R4"); chk("R4 sticky, falling ignored", last_rd, 32'h04);
    wr('h70, 32'h00, "R7"); rd('h40, "R7");
    chk("R7 zero write keeps status", last_rd, 32'h04);
    wr('h70, 32'h04, "R7"); rd('h40, "R7");
    chk("R7 one clears status", last_rd, 32'h0);
    chk("R9 irq drops after clear", {31'b0, irq}, 32'h0);

    // edge and clear in the same cycle
    pins[2] = 1'b1; tick("R8"); pins[2] = 1'b0; tick("R8");
    pins[2] = 1'b1; wr('h70, 32'h04, "R8"); rd('h40, "R8");
    chk("R8 edge beats clear", last_rd, 32'h04);
    wr('h70, 32'h04, "R8"); rd('h40, "R8");
    chk("R8 later clear works", last_rd, 32'h0);

    // port1 pin1 falling
    pins[9] = 1'b1; wr('h64, 32'h0000_02FD, "R3"); wr('h74, 32'hFF, "R7");
    rd('h44, "R4"); chk("R4 falling idle", last_rd, 32'h0);
    pins[9] = 1'b0; tick("R4"); rd('h44, "R4");
    chk("R4 falling sets status", last_rd, 32'h02);

    // port2 pin5 both edges
    wr('h68, 32'h0020_20DF, "R3"); wr('h78, 32'hFF, "R7");
    rd('h48, "R5"); chk("R5 idle", last_rd, 32'h0);
    pins[21] = 1'b1; tick("R5"); rd('h48, "R5");
    chk("R5 rise sets", last_rd, 32'h20);
    wr('h78, 32'h20, "R5"); rd('h48, "R5"); chk("R5 cleared", last_rd, 32'h0);
    pins[21] = 1'b0; tick("R5"); rd('h48, "R5");
    chk("R5 fall sets", last_rd, 32'h20);

    // port3 level high
    wr('h6C, 32'h0000_00FF, "R3"); wr('h7C, 32'hFF, "R7");
    rd('h4C, "R6"); chk("R6 idle", last_rd, 32'h0);
    pins[24] = 1'b1; tick("R6"); rd('h4C, "R6");
    chk("R6 high level sets", last_rd, 32'h01);
    wr('h7C, 32'h01, "R6"); rd('h4C, "R6");
    chk("R6 clear ineffective while high", last_rd, 32'h01);
    pins[24] = 1'b0; tick("R6"); rd('h4C, "R6");
    chk("R6 stays after level gone", last_rd, 32'h01);
    wr('h7C, 32'h01, "R6"); rd('h4C, "R6");
    chk("R6 clears once level gone", last_rd, 32'h0);
    wr('h6C, 32'h0000_00FE, "R3"); tick("R3"); rd('h4C, "R3");
    chk("R3 low level encoding", last_rd, 32'h01);

    // masked aliases
    wr('h54, 32'h02, "R10"); wr(AW'(UP + 'h54), 32'h8101, "R10");
    rd('h54, "R10"); chk("R10 masked enable", last_rd, 32'h03);
    wr(AW'(UP + 'h54), 32'h00FF, "R10"); rd('h54, "R10");
    chk("R10 zero mask no change", last_rd, 32'h03);
    wr(AW'(UP + 'h64), 32'h0F05, "R11"); rd('h64, "R11");
    chk("R11 masked polarity only", last_rd, 32'h0000_02F5);
    rd(AW'(UP + 'h54), "R2"); chk("R2 alias reads zero", last_rd, 32'h0);

    // random traffic against the model
    for (int i = 0; i < 2500; i++) begin
      int op, p;
      if ($urandom % 4 == 0) pins[$urandom % 32] ^= 1'b1;
      op = $urandom % 10;
      p  = $urandom % NP;
      case (op)
        0: wr(AW'('h60 + 4*p), $urandom & 32'h00FF_FFFF, "R3 R4 R5 R6 rand");
        1: wr(AW'('h50 + 4*p), $urandom & 32'hFF, "R9 rand");
        2: wr(AW'('h70 + 4*p), $urandom & 32'hFF, "R7 R8 rand");
        3: wr(AW'(UP + 'h50 + 4*p), $urandom & 32'hFFFF, "R10 rand");
        4: wr(AW'(UP + 'h60 + 4*p), $urandom & 32'hFFFF, "R11 rand");
        default: rd(AW'('h40 + 16*($urandom % 3) + 4*p), "R2 R12 rand");
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule